// File: doc/BRIEF.md
# Infrared pulse run-length sampler

This block sits behind the receive pin of a consumer-IR front end whose carrier has already been removed. It samples the line once per tick, where a tick is one in every `DIV` clocks of the module clock (64 by default, so an 8 MHz clock gives an 8 us sample). Each stretch of constant line level is turned into one byte: the level in the top bit and the length, counted in samples, below it. The byte is offered once, for a single cycle, to a downstream receive FIFO.

Short opposite-level glitches are folded into the run they interrupt. A long enough space closes the packet: the final space byte is sent together with a packet-end strobe, and the block then waits in silence for the next mark. The input can be inverted before any of this happens. The sampler only runs while the global enable and the receive enable are both set and the mode field selects consumer-IR capture. Dropping any of these clears all run state at the next clock edge.

The controller is a three-state machine. `ST_WAIT` waits for a mark and goes to `ST_MARK` on a mark sample (start). `ST_MARK` goes to `ST_SPACE`, and `ST_SPACE` goes back to `ST_MARK`, when a level change outlasts the noise threshold (confirm). `ST_SPACE` goes to `ST_WAIT` when the space outlasts the idle threshold (packet end). Every state returns to `ST_WAIT` when the block is deactivated.

Top module: `ir_runlen_sampler`

## Requirements
- R1: A sample is taken on the `DIV`-th clock edge after activation and then on every `DIV`-th edge. All lengths are counted in these samples.
- R2: Each entry byte carries the run level in bit 7 (1 = mark, 0 = space) and the run length minus one in bits 6:0.
- R3: When `invert` is 1, the line is complemented before sampling, so a low `ir_in` counts as a mark.
- R4: An opposite-level stretch of at most `noise_thr` samples is absorbed and its samples add to the current run. A stretch of `noise_thr`+1 samples ends the run, and the new run starts with those samples already counted.
- R5: When the total length of a space exceeds `idle_thr` samples, the block emits that space as an entry and pulses `pkt_end` in the same cycle as that entry's `ent_valid`. The entry holds the current piece of the space, capped at 128 samples.
- R6: After activation and after packet end, no entry is produced while the line stays at space level. The first entry that follows is a mark.
- R7: A run longer than 128 samples emits an entry with length code 127 for the first 128 samples. The remaining samples of the same level continue in a fresh entry.
- R8: The block is active only when `glb_en`=1, `rx_en`=1 and `mode_sel`=2'b11. Otherwise it produces no entries and no `pkt_end`.
- R9: Deactivation clears the sample divider, the run counters, the glitch filter and the idle detector at the next clock edge. A run cut short this way is discarded.
- R10: `ent_valid` is high for exactly one cycle per entry. `ovf` is high in any cycle where `ent_valid` is high and `ent_ready` is low, and that entry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode_sel | input | 2 | Capture mode; 2'b11 selects consumer-IR |
| invert | input | 1 | Complement the line before sampling |
| noise_thr | input | 6 | Longest glitch, in samples, that is absorbed |
| idle_thr | input | 8 | Space length, in samples, that must be exceeded for packet end |
| ent_ready | input | 1 | FIFO can accept an entry |
| ent_valid | output | 1 | Entry present this cycle |
| ent_data | output | 8 | Entry: level bit and length code |
| pkt_end | output | 1 | Packet-end strobe |
| ovf | output | 1 | Entry offered while FIFO full |

## Verification
The pattern table drives a mark, a middle space and a second mark, then a long trailing space. Across its rows it varies the noise threshold, the length of the middle space, and the polarity. One glitch falls just inside the threshold and one just outside, which separates absorption from confirmation. A short trailing mark is swallowed by the idle space, which shows that the filter also applies to space runs. A 130-sample mark and a 210-sample idle space exercise chunking on both levels, including a packet end that lands inside a second chunk. Directed cases cover a non-capture mode, a mid-run enable drop, a small idle threshold followed by a silent tail, and a FIFO held full.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } rl_state_e;

    localparam logic [1:0] CIR_MODE = 2'b11;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = active && (cnt_q == LAST);
endmodule

// File: rtl/ir_run_fsm.sv
module ir_run_fsm
    import ir_rl_pkg::*;
#(
    parameter int CODE_W  = 7,
    parameter int NOISE_W = 6,
    parameter int IDLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                tick,
    input  logic                smp,
    input  logic [NOISE_W-1:0]  noise_thr,
    input  logic [IDLE_W-1:0]   idle_thr,
    output logic                ent_valid,
    output logic [CODE_W:0]     ent_data,
    output logic                pkt_end
);
    localparam int LEN_W = CODE_W + 2;
    localparam int G_W   = NOISE_W + 1;
    localparam int SP_W  = IDLE_W + 2;
    localparam logic [LEN_W-1:0] MAX_RUN = LEN_W'(1 << CODE_W);

    rl_state_e          st_q, st_d;
    logic [LEN_W-1:0]   run_q, run_d;
    logic [G_W-1:0]     g_q, g_d;
    logic [SP_W-1:0]    sp_q, sp_d;

    logic               emit, lvl, pkt;
    logic [LEN_W-1:0]   emit_len;
    logic [LEN_W-1:0]   sum;
    logic [SP_W-1:0]    sp_sum;
    logic [G_W-1:0]     g_inc;
    logic               cur;

    always_comb begin
        sum    = run_q + LEN_W'(g_q) + LEN_W'(1);
        sp_sum = sp_q + SP_W'(g_q) + SP_W'(1);
        g_inc  = g_q + G_W'(1);
        cur    = (st_q == ST_MARK);
    end

    // next-state and emitted-entry logic
    always_comb begin
        st_d     = st_q;
        run_d    = run_q;
        g_d      = g_q;
        sp_d     = sp_q;
        emit     = 1'b0;
        lvl      = 1'b0;
        pkt      = 1'b0;
        emit_len = LEN_W'(1);
        if (tick) begin
            unique case (st_q)
                ST_WAIT: begin
                    if (smp) begin
                        st_d  = ST_MARK;
                        run_d = LEN_W'(1);
                        g_d   = '0;
                        sp_d  = '0;
                    end
                end
                ST_MARK, ST_SPACE: begin
                    if (smp == cur) begin
                        g_d = '0;
                        if (!cur && (sp_sum > SP_W'(idle_thr))) begin
                            emit     = 1'b1;
                            pkt      = 1'b1;
                            emit_len = (sum > MAX_RUN) ? MAX_RUN : sum;
                            st_d     = ST_WAIT;
                            run_d    = '0;
                            sp_d     = '0;
                        end else if (sum > MAX_RUN) begin
                            emit     = 1'b1;
                            lvl      = cur;
                            emit_len = MAX_RUN;
                            run_d    = sum - MAX_RUN;
                            sp_d     = sp_sum;
                        end else begin
                            run_d = sum;
                            sp_d  = sp_sum;
                        end
                    end else if (g_inc > G_W'(noise_thr)) begin
                        emit     = 1'b1;
                        lvl      = cur;
                        emit_len = run_q;
                        st_d     = cur ? ST_SPACE : ST_MARK;
                        run_d    = LEN_W'(g_inc);
                        sp_d     = SP_W'(g_inc);
                        g_d      = '0;
                    end else begin
                        g_d = g_inc;
                    end
                end
                default: st_d = ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            st_q  <= ST_WAIT;
            run_q <= '0;
            g_q   <= '0;
            sp_q  <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
            g_q   <= g_d;
            sp_q  <= sp_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ent_valid <= 1'b0;
            ent_data  <= '0;
            pkt_end   <= 1'b0;
        end else begin
            ent_valid <= emit;
            pkt_end   <= pkt;
            if (emit) begin
                ent_data <= {lvl, CODE_W'(emit_len - LEN_W'(1))};
            end
        end
    end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int DIV     = 64,
    parameter int CODE_W  = 7,
    parameter int NOISE_W = 6,
    parameter int IDLE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_in,
    input  logic               glb_en,
    input  logic               rx_en,
    input  logic [1:0]         mode_sel,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               ent_ready,
    output logic               ent_valid,
    output logic [CODE_W:0]    ent_data,
    output logic               pkt_end,
    output logic               ovf
);
    logic active;
    logic tick;
    logic smp;

    assign active = glb_en && rx_en && (mode_sel == CIR_MODE);
    assign smp    = ir_in ^ invert;

    ir_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick)
    );

    ir_run_fsm #(
        .CODE_W  (CODE_W),
        .NOISE_W (NOISE_W),
        .IDLE_W  (IDLE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .smp       (smp),
        .noise_thr (noise_thr),
        .idle_thr  (idle_thr),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .pkt_end   (pkt_end)
    );

    assign ovf = ent_valid && !ent_ready;
endmodule

// File: rtl/ir_runlen_checker.sv
module ir_runlen_checker #(
    parameter int CODE_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            glb_en,
    input logic            rx_en,
    input logic [1:0]      mode_sel,
    input logic            ent_valid,
    input logic [CODE_W:0] ent_data,
    input logic            pkt_end
);
    logic on;
    logic expect_mark;

    assign on = glb_en && rx_en && (mode_sel == 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n || !on || pkt_end) begin
            expect_mark <= 1'b1;
        end else if (ent_valid) begin
            expect_mark <= 1'b0;
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (!ent_valid && !pkt_end)); // R8

    AST_PKT_WITH_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (ent_valid && !ent_data[CODE_W])); // R5

    AST_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (expect_mark && ent_valid) |-> ent_data[CODE_W]); // R6

    AST_ONE_CYCLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !ent_valid); // R10
endmodule

bind ir_runlen_sampler ir_runlen_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .rx_en     (rx_en),
    .mode_sel  (mode_sel),
    .ent_valid (ent_valid),
    .ent_data  (ent_data),
    .pkt_end   (pkt_end)
);

// File: tb/ir_runlen_sampler_test.sv
module ir_runlen_sampler_test;
    localparam int DIV = 4;

    typedef struct packed {
        logic            inv;
        logic [5:0]      n;
        logic [7:0]      a;
        logic [7:0]      b;
        logic [7:0]      c;
        logic [2:0]      cnt;
        logic [5:0][7:0] e;
    } vec_t;

    // row: invert, noise, mark a, space b, mark c, entry count, entries (first at e[0])
    localparam vec_t VEC [5] = '{
        '{1'b0, 6'd0, 8'd5,   8'd3, 8'd4, 3'd4, {8'h00, 8'h00, 8'h14, 8'h83, 8'h02, 8'h84}},
        '{1'b0, 6'd2, 8'd5,   8'd2, 8'd4, 3'd2, {8'h00, 8'h00, 8'h00, 8'h00, 8'h14, 8'h8A}},
        '{1'b0, 6'd2, 8'd6,   8'd3, 8'd2, 3'd2, {8'h00, 8'h00, 8'h00, 8'h00, 8'h14, 8'h85}},
        '{1'b1, 6'd0, 8'd2,   8'd2, 8'd2, 3'd4, {8'h00, 8'h00, 8'h14, 8'h81, 8'h01, 8'h81}},
        '{1'b0, 6'd0, 8'd130, 8'd4, 8'd1, 3'd5, {8'h00, 8'h14, 8'h80, 8'h03, 8'h81, 8'hFF}}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b1;
    logic [1:0] mode_sel = 2'b11;
    logic       invert = 1'b0;
    logic [5:0] noise_thr = 6'd0;
    logic [7:0] idle_thr = 8'd20;
    logic       ent_ready = 1'b1;
    logic       ent_valid;
    logic [7:0] ent_data;
    logic       pkt_end;
    logic       ovf;

    int n_checks = 0;
    int n_fail = 0;
    int pkt_cnt = 0;
    int ovf_cnt = 0;
    logic [7:0] got[$];
    logic cur_inv = 1'b0;
    logic [1:0] mode_v = 2'b11;
    logic glb_v = 1'b1;

    always #5 clk = ~clk;

    ir_runlen_sampler #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .glb_en(glb_en), .rx_en(rx_en),
        .mode_sel(mode_sel), .invert(invert), .noise_thr(noise_thr),
        .idle_thr(idle_thr), .ent_ready(ent_ready), .ent_valid(ent_valid),
        .ent_data(ent_data), .pkt_end(pkt_end), .ovf(ovf)
    );

    always @(negedge clk) begin
        if (ent_valid) got.push_back(ent_data);
        if (pkt_end) pkt_cnt++;
        if (ovf) ovf_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic drive(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            ir_in = lvl ^ cur_inv;
            repeat (DIV) @(negedge clk);
        end
    endtask

    task automatic begin_row(input logic inv, input logic [5:0] n, input logic [7:0] ithr);
        @(negedge clk);
        glb_en = 1'b0;
        repeat (2) @(negedge clk);
        got.delete();
        pkt_cnt = 0;
        ovf_cnt = 0;
        cur_inv = inv;
        invert = inv;
        noise_thr = n;
        idle_thr = ithr;
        ir_in = inv;
        mode_sel = mode_v;
        glb_en = glb_v;
        drive(1'b0, 2);
    endtask

    task automatic expect_entries(input string tag, input int cnt,
                                  input logic [5:0][7:0] e, input int pk);
        repeat (4) @(negedge clk);
        chk(got.size() == cnt, {tag, " entry count"}, got.size(), cnt);
        for (int i = 0; i < cnt; i++) begin
            if (i < got.size())
                chk(got[i] == e[i], {tag, " entry"}, got[i], e[i]);
        end
        chk(pkt_cnt == pk, {tag, " pkt_end count"}, pkt_cnt, pk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, block idle
        chk(ent_valid == 1'b0, "R10 reset ent_valid", ent_valid, 0);
        chk(pkt_end == 1'b0, "R5 reset pkt_end", pkt_end, 0);
        chk(ovf == 1'b0, "R10 reset ovf", ovf, 0);

        // pattern table: R1 R2 R3 R4 R5 R7
        for (int r = 0; r < 5; r++) begin
            begin_row(VEC[r].inv, VEC[r].n, 8'd20);
            drive(1'b1, VEC[r].a);
            drive(1'b0, VEC[r].b);
            drive(1'b1, VEC[r].c);
            drive(1'b0, 24);
            expect_entries($sformatf("R1/R2/R4 row %0d", r), VEC[r].cnt, VEC[r].e, 1);
        end

        // R5 small idle threshold, then R6 silence on a continued space
        begin_row(1'b0, 6'd0, 8'd5);
        drive(1'b1, 3);
        drive(1'b0, 20);
        expect_entries("R5/R6 idle_thr=5", 2, {8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h82}, 1);

        // R7 long idle space is chunked, packet end inside second chunk
        begin_row(1'b0, 6'd0, 8'd200);
        drive(1'b1, 2);
        drive(1'b0, 210);
        expect_entries("R7 long space", 3, {8'h00, 8'h00, 8'h00, 8'h48, 8'h7F, 8'h81}, 1);

        // R8 wrong mode: nothing produced
        mode_v = 2'b01;
        begin_row(1'b0, 6'd0, 8'd5);
        drive(1'b1, 4);
        drive(1'b0, 10);
        expect_entries("R8 mode 01", 0, '0, 0);
        mode_v = 2'b11;

        // R8 global enable off
        glb_v = 1'b0;
        begin_row(1'b0, 6'd0, 8'd5);
        drive(1'b1, 4);
        drive(1'b0, 10);
        expect_entries("R8 glb_en off", 0, '0, 0);
        glb_v = 1'b1;

        // R9 receive enable dropped mid-run discards the partial mark
        begin_row(1'b0, 6'd0, 8'd20);
        drive(1'b1, 5);
        ir_in = 1'b0;
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        drive(1'b0, 2);
        drive(1'b1, 3);
        drive(1'b0, 24);
        expect_entries("R9 enable drop", 2, {8'h00, 8'h00, 8'h00, 8'h00, 8'h14, 8'h82}, 1);

        // R10 FIFO full: every entry flagged as overflow
        ent_ready = 1'b0;
        begin_row(1'b0, 6'd0, 8'd20);
        drive(1'b1, 3);
        drive(1'b0, 24);
        repeat (4) @(negedge clk);
        chk(ovf_cnt == 2, "R10 overflow count", ovf_cnt, 2);
        chk(got.size() == 2, "R10 entries offered while full", got.size(), 2);
        ent_ready = 1'b1;

        report();
    end
endmodule